// File: doc/BRIEF.md
# HDLC Receive Frame Length Limiter

This block sits on the receive side of an HDLC engine, after flag detection and zero-bit removal. It receives one octet at a time, together with markers that tag the first and last octet of a frame. It counts every octet the frame carries: address, control, information and FCS octets all count the same. The limit is a single 16-bit value shared by every channel. A separate enable turns length checking on or off.

When checking is on and a frame grows past the limit, the block stops the frame at that point. The octet that went over the limit is not forwarded. A one-cycle abort pulse is raised instead. Every later octet of the same frame is discarded, including the closing one, so no good-frame completion is signalled. Forwarding resumes at the next frame start. Frames within the limit pass unchanged, one clock cycle late.

Top module: `lhl_len_limiter`

## Requirements
- R1: While reset is applied, and in the first cycle after it, `out_valid`, `out_sof`, `out_eof` and `out_abort` are all 0.
- R2: An octet accepted and not suppressed appears on `out_data` with `out_valid` high exactly one cycle after it is presented. Its `out_sof` and `out_eof` equal the input markers. `out_sof`/`out_eof` are never high without `out_valid`.
- R3: The length of a frame counts every octet from the one marked `in_sof` through the one marked `in_eof`, both included. A frame whose length equals `cfg_max_len` passes complete, with its end marker.
- R4: With `cfg_len_en` = 1, the octet that takes the count to `cfg_max_len` + 1 is not forwarded. In its output slot `out_abort` is high for one cycle and `out_valid` is low. If that octet also carries the end marker, no `out_eof` appears.
- R5: After an abort, every remaining octet of the frame is suppressed, the end-of-frame octet included. No further abort is raised for that frame. The next output is the start of a new frame.
- R6: With `cfg_len_en` = 0, no frame is limited and `out_abort` stays 0, whatever `cfg_max_len` holds.
- R7: With `cfg_len_en` = 1 and `cfg_max_len` = 0, the first octet of any frame triggers an abort.
- R8: The octet count saturates at 2^LEN_W-1 and never wraps. The enable and limit are applied to each octet as it arrives. A frame already longer than 65535 octets is therefore aborted when checking is switched on with a limit of 65534.
- R9: An octet marked `in_sof` always starts a new frame with count 1. This holds mid-frame and after an abort.
- R10: An octet presented while no frame is open and without `in_sof` is discarded, with no output and no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Octet strobe |
| in_data | input | 8 | Octet value |
| in_sof | input | 1 | Octet is the first after the opening flag |
| in_eof | input | 1 | Octet is the last before the closing flag |
| cfg_max_len | input | 16 | Global maximum frame length in octets |
| cfg_len_en | input | 1 | Length check enable |
| out_valid | output | 1 | Forwarded octet strobe |
| out_data | output | 8 | Forwarded octet |
| out_sof | output | 1 | Forwarded start marker |
| out_eof | output | 1 | Good frame completion marker |
| out_abort | output | 1 | One-cycle pulse: frame cut for length |

## Verification
The bench targets the edges of the limit. It sends a frame exactly at the limit, which an off-by-one design would abort. It sends a frame one octet over, which a design comparing with greater-or-equal would treat wrongly, and one where the overflowing octet is also the last, which a careless design would close with a good end marker. It checks that octets after an abort stay silent with a single pulse, that a limit of zero cuts the first octet, and that stray octets outside any frame vanish. A frame of over 65,536 octets is followed by switching checking on with a limit of 65,534. A wrapping counter would miss this abort.

// File: rtl/lhl_pkg.sv
package lhl_pkg;
  // Fate of one presented octet
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,  // nothing presented or not part of a frame
    ACT_PASS  = 2'd1,  // forwarded
    ACT_ABORT = 2'd2,  // octet that broke the limit
    ACT_DROP  = 2'd3   // tail of an already cut frame
  } act_e;
endpackage

// File: rtl/lhl_frame_tracker.sv
module lhl_frame_tracker #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oct_vld,
  input  logic             oct_sof,
  input  logic             oct_eof,
  output logic             member_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] LEN_TOP = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic             open_q, open_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    member_o = oct_vld && (oct_sof || open_q);
    if (oct_sof)              len_o = LEN_ONE;
    else if (cnt_q == LEN_TOP) len_o = cnt_q;
    else                      len_o = cnt_q + LEN_ONE;
    cnt_en = member_o;
    cnt_d  = len_o;
    open_d = open_q;
    if (oct_vld && oct_sof)   open_d = 1'b1;
    if (member_o && oct_eof)  open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  // count never wraps once at the top
  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LEN_TOP && oct_vld && open_q && !oct_sof) |=> cnt_q == LEN_TOP);
  // a start octet always restarts the count at one
  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (oct_vld && oct_sof) |=> cnt_q == LEN_ONE);
endmodule

// File: rtl/lhl_limit_judge.sv
module lhl_limit_judge
  import lhl_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             member_i,
  input  logic             sof_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] max_i,
  input  logic             en_i,
  output act_e             act_o
);
  logic drop_q, drop_d;
  logic drop_eff, over;

  always_comb begin
    drop_eff = drop_q && !sof_i;
    over     = en_i && (len_i > max_i);
    if (!member_i)     act_o = ACT_IDLE;
    else if (drop_eff) act_o = ACT_DROP;
    else if (over)     act_o = ACT_ABORT;
    else               act_o = ACT_PASS;
    drop_d = drop_q;
    if (member_i) drop_d = (act_o == ACT_ABORT) || (act_o == ACT_DROP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= drop_d;
  end

  // an abort is followed by silence until the next start octet
  assert_single_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o == ACT_ABORT) |=> (act_o != ACT_PASS || sof_i));
endmodule

// File: rtl/lhl_out_stage.sv
module lhl_out_stage
  import lhl_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  act_e              act_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sof_i,
  input  logic              eof_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic              abort_o
);
  logic pass;
  logic valid_d, sof_d, eof_d, abort_d;

  always_comb begin
    pass    = (act_i == ACT_PASS);
    valid_d = pass;
    sof_d   = pass && sof_i;
    eof_d   = pass && eof_i;
    abort_d = (act_i == ACT_ABORT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      eof_o   <= 1'b0;
      abort_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_d;
      sof_o   <= sof_d;
      eof_o   <= eof_d;
      abort_o <= abort_d;
      if (pass) data_o <= data_i;
    end
  end
endmodule

// File: rtl/lhl_len_limiter.sv
module lhl_len_limiter
  import lhl_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              cfg_len_en,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_abort
);
  // reset: asserted at once, released after SYNC_N edges
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC_N-1];

  logic             member;
  logic [LEN_W-1:0] cur_len;
  act_e             act;

  lhl_frame_tracker #(.LEN_W(LEN_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .oct_vld  (in_valid),
    .oct_sof  (in_sof),
    .oct_eof  (in_eof),
    .member_o (member),
    .len_o    (cur_len)
  );

  lhl_limit_judge #(.LEN_W(LEN_W)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .member_i (member),
    .sof_i    (in_sof),
    .len_i    (cur_len),
    .max_i    (cfg_max_len),
    .en_i     (cfg_len_en),
    .act_o    (act)
  );

  lhl_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .act_i   (act),
    .data_i  (in_data),
    .sof_i   (in_sof),
    .eof_i   (in_eof),
    .valid_o (out_valid),
    .data_o  (out_data),
    .sof_o   (out_sof),
    .eof_o   (out_eof),
    .abort_o (out_abort)
  );

  assert_abort_excl_R4: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    out_abort |-> !out_valid);
  assert_marks_need_valid_R2: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    (out_sof || out_eof) |-> out_valid);
  assert_zero_limit_R7: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    (cfg_len_en && cfg_max_len == '0 && in_valid && in_sof) |=> out_abort);
  assert_after_abort_R5: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    out_abort |=> (!out_valid || out_sof));
  assert_no_limit_off_R6: assert property (@(posedge clk) disable iff (!rst_n || !rst_n_s)
    !cfg_len_en |=> !out_abort);
endmodule

// File: tb/lhl_len_limiter_tb.sv
module lhl_len_limiter_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof, cfg_len_en;
  logic [7:0]  in_data, out_data;
  logic [15:0] cfg_max_len;
  logic        out_valid, out_sof, out_eof, out_abort;

  int checks = 0;
  int fails  = 0;
  bit mon_on = 0;

  typedef struct { logic [10:0] item; string tag; } exp_t;
  exp_t q[$];

  // reference model state
  bit m_open = 0;
  bit m_drop = 0;
  int m_cnt  = 0;

  lhl_len_limiter u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .cfg_max_len(cfg_max_len),
    .cfg_len_en(cfg_len_en), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_abort(out_abort)
  );

  initial clk = 0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic push(input logic [10:0] it, input string tg);
    exp_t e;
    e.item = it; e.tag = tg;
    q.push_back(e);
  endtask

  // expected fate of one octet, derived from R2..R10
  task automatic model(input logic [7:0] d, input logic s, input logic e, input string tg);
    if (s) begin m_cnt = 1; m_open = 1; m_drop = 0; end       // R9
    else if (!m_open) return;                                  // R10
    else if (m_cnt < 65535) m_cnt++;                           // R8 saturation
    if (e) m_open = 0;
    if (m_drop) return;                                        // R5
    if (cfg_len_en && m_cnt > int'(cfg_max_len)) begin         // R4
      m_drop = 1;
      push({1'b1, 1'b0, 1'b0, 8'h00}, tg);
      return;
    end
    push({1'b0, s, e, d}, tg);
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e, input string tg);
    in_valid = 1; in_data = d; in_sof = s; in_eof = e;
    model(d, s, e, tg);
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
  endtask

  task automatic frame(input int n, input logic [7:0] base, input string tg);
    for (int i = 0; i < n; i++) put(base + 8'(i), i == 0, i == n - 1, tg);
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares every output event against the queue
  always @(negedge clk) begin
    if (mon_on && (out_valid || out_abort)) begin
      logic [10:0] obs;
      exp_t e;
      obs = {out_abort, out_sof, out_eof, out_valid ? out_data : 8'h00};
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R5 R10 stray output: got %h expected none", obs);
      end else begin
        e = q.pop_front();
        if (obs !== e.item) begin
          fails++;
          $display("FAIL %s: got %h expected %h", e.tag, obs, e.item);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
    cfg_max_len = 16'd0; cfg_len_en = 0;
    gap(3);
    // R1: outputs quiet during reset
    checks++;
    if ({out_valid, out_sof, out_eof, out_abort} !== 4'b0) begin
      fails++;
      $display("FAIL R1: got %b expected 0000", {out_valid, out_sof, out_eof, out_abort});
    end
    rst_n = 1;
    gap(4);
    checks++;
    if ({out_valid, out_sof, out_eof, out_abort} !== 4'b0) begin
      fails++;
      $display("FAIL R1: got %b expected 0000 after release", {out_valid, out_sof, out_eof, out_abort});
    end
    mon_on = 1;

    cfg_len_en = 1; cfg_max_len = 16'd10;
    frame(5, 8'h10, "R2");                  // R2 short frame passes
    gap(2);
    cfg_max_len = 16'd4;
    frame(4, 8'h20, "R3");                  // R3 exactly at limit
    gap(1);
    frame(7, 8'h30, "R4");                  // R4 cut at octet 5, R5 tail silent
    gap(2);
    frame(5, 8'h40, "R4");                  // overflow octet is also the last
    gap(1);
    frame(1, 8'h50, "R3");                  // single-octet frame
    put(8'h51, 0, 0, "R10");                // R10 stray octets
    put(8'h52, 0, 1, "R10");
    gap(1);
    cfg_len_en = 0;
    frame(20, 8'h60, "R6");                 // R6 no limit when off
    cfg_len_en = 1; cfg_max_len = 16'd0;
    frame(3, 8'h80, "R7");                  // R7 zero limit
    gap(1);
    cfg_max_len = 16'd3;
    put(8'h90, 1, 0, "R9");                 // R9 restart after abort
    for (int i = 1; i < 5; i++) put(8'h90 + 8'(i), 0, 0, "R5");
    frame(3, 8'hA0, "R9");
    // R9 restart mid-frame in a good frame
    put(8'hB0, 1, 0, "R9");
    put(8'hB1, 0, 0, "R9");
    frame(3, 8'hC0, "R9");
    gap(2);
    // R8 saturation: very long frame, then switch the check on
    cfg_len_en = 0;
    put(8'h00, 1, 0, "R8");
    for (int i = 1; i < 65540; i++) put(8'(i), 0, 0, "R8");
    cfg_len_en = 1; cfg_max_len = 16'hFFFE;
    put(8'hEE, 0, 0, "R8");
    put(8'hEF, 0, 1, "R8");
    gap(1);
    frame(2, 8'hD0, "R9");
    gap(4);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R2: got %0d pending expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule